// File: doc/BRIEF.md
# Serial-Output Sequencer for a Successive-Approximation Converter

This block models the digital control and serial read-out side of a 12-bit successive-approximation converter. A parallel result word stands in for the analog comparator array; the block turns it into the bit-serial stream a host reads over a three-wire link. The link has an active-low select that doubles as shutdown, a host-driven data clock, and a serial data line that can be released to high impedance.

The host lowers the select and then toggles the data clock. The first two falling data-clock edges form the sampling window. On the second one the line is driven with a low null bit. The next twelve falling edges present the result most significant bit first. After bit 0 a configuration input picks the tail. In the first tail the word is replayed least significant bit first, up to bit 11, and then the line is released. In the other tail the line holds zeros for as long as the clock runs. Raising the select cancels any frame at once. A new frame needs a fresh high-to-low transition of the select.

The data clock and select are treated as slow signals. A local system clock samples them, and every output update lands one system-clock cycle after the data-clock edge is seen. Status flags report sampling, conversion in progress, analog power-down (select high, or all result bits already decided) and full power-down (select high).

Top module: `sar_serial_seq`

## Requirements
- R1: After the select falls, the sampling flag is high and the data line is not driven until the second falling data-clock edge; the sampling flag is still high after the first falling edge.
- R2: On the second falling edge after the select falls, the output enable goes high with data 0 (the null bit) and the converting flag goes high.
- R3: Falling edges 3 to 14 of a frame present result bits 11 down to 0, one bit per edge. The data line changes only on a falling data-clock edge or a select change.
- R4: Each bit is taken from the result input at the falling edge that presents it, so a result change between edges shows up in the very next bit.
- R5: With zero_tail = 0, edges 15 to 25 present bits 1 up to 11. From edge 26 on the line is released, and further edges or result changes have no effect while the select stays low.
- R6: With zero_tail = 1, from edge 15 on the line stays enabled and drives 0 indefinitely.
- R7: A high select releases the line and raises the full power-down flag within one system-clock cycle, cancelling a frame in progress. A later falling select restarts from sampling.
- R8: At most one of the sampling, converting and analog power-down flags is high. Analog power-down is high from edge 15 on and whenever the select is high.
- R9: After reset the line is released and both power-down flags are high.
- R10: Codes are straight binary: result 000h reads as twelve 0 bits and FFFh as twelve 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| dclk | input | 1 | Host data clock; bits change on its falling edge |
| zero_tail | input | 1 | 0: replay LSB first then release; 1: drive zeros after bit 0 |
| result | input | 12 | Stand-in comparator result word, straight binary |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data enable; 0 means high impedance |
| sampling | output | 1 | Sampling window active |
| converting | output | 1 | Null bit or MSB-first bit being output |
| analog_off | output | 1 | Analog section powered down |
| full_off | output | 1 | Full power-down (select high) |

## Verification
The bench builds the block with its defaults: a 12-bit word and a two-edge sampling window. With these values a whole frame, including the LSB-first replay and the release after edge 25, fits in under thirty data-clock periods. That makes both tail modes, a frame aborted partway, and the idle edges after release all reachable in one short run. Result words with alternating, all-zero, all-one and mid-frame-changing patterns expose bit-order and pipeline errors.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_NULL   = 3'd2,
        ST_MSB    = 3'd3,
        ST_LSB    = 3'd4,
        ST_ZERO   = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/sar_fall_detect.sv
module sar_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    logic din_d, din_q;

    always_comb begin
        din_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din_d;
    end

    assign fall = din_q & ~din;

endmodule

// File: rtl/sar_bit_pick.sv
module sar_bit_pick #(
    parameter int WIDTH = 12,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    input  logic [IDXW-1:0]  idx,
    output logic             bit_o
);

    logic [WIDTH-1:0] sel;

    for (genvar g = 0; g < WIDTH; g++) begin : g_sel
        assign sel[g] = (idx == IDXW'(g)) & word[g];
    end

    assign bit_o = |sel;

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int SMP_EDGES = 2,
    localparam int IDXW = $clog2(WIDTH),
    localparam int SCW  = $clog2(SMP_EDGES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            fall,
    input  logic            zero_tail,
    input  logic            pick_bit,
    output logic [IDXW-1:0] pick_idx,
    output seq_state_e      state,
    output logic            dout,
    output logic            dout_oe
);

    typedef struct packed {
        seq_state_e      st;
        logic [SCW-1:0]  smp;
        logic [IDXW-1:0] idx;
        logic            dout;
        logic            oe;
        logic            cs_q;
    } seq_regs_t;

    localparam logic [IDXW-1:0] IDX_TOP = IDXW'(WIDTH - 1);

    seq_regs_t r_d, r_q;

    always_comb begin
        case (r_q.st)
            ST_NULL: pick_idx = IDX_TOP;
            ST_MSB:  pick_idx = (r_q.idx == '0) ? IDXW'(1) : r_q.idx - IDXW'(1);
            default: pick_idx = r_q.idx + IDXW'(1);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.cs_q = cs_n;
        if (cs_n) begin
            r_d.st   = ST_OFF;
            r_d.oe   = 1'b0;
            r_d.dout = 1'b0;
            r_d.smp  = '0;
            r_d.idx  = '0;
        end else begin
            case (r_q.st)
                ST_OFF: begin
                    if (r_q.cs_q) begin
                        r_d.st  = ST_SAMPLE;
                        r_d.smp = '0;
                    end
                end
                ST_SAMPLE: begin
                    if (fall) begin
                        if (r_q.smp == SCW'(SMP_EDGES - 1)) begin
                            r_d.st   = ST_NULL;
                            r_d.oe   = 1'b1;
                            r_d.dout = 1'b0;
                        end else begin
                            r_d.smp = r_q.smp + SCW'(1);
                        end
                    end
                end
                ST_NULL: begin
                    if (fall) begin
                        r_d.st   = ST_MSB;
                        r_d.idx  = pick_idx;
                        r_d.dout = pick_bit;
                    end
                end
                ST_MSB: begin
                    if (fall) begin
                        if (r_q.idx == '0) begin
                            if (zero_tail) begin
                                r_d.st   = ST_ZERO;
                                r_d.dout = 1'b0;
                            end else begin
                                r_d.st   = ST_LSB;
                                r_d.idx  = pick_idx;
                                r_d.dout = pick_bit;
                            end
                        end else begin
                            r_d.idx  = pick_idx;
                            r_d.dout = pick_bit;
                        end
                    end
                end
                ST_LSB: begin
                    if (fall) begin
                        if (r_q.idx == IDX_TOP) begin
                            r_d.st   = ST_DONE;
                            r_d.oe   = 1'b0;
                            r_d.dout = 1'b0;
                        end else begin
                            r_d.idx  = pick_idx;
                            r_d.dout = pick_bit;
                        end
                    end
                end
                ST_ZERO: begin
                    r_d.dout = 1'b0;
                end
                default: begin
                    r_d.oe   = 1'b0;
                    r_d.dout = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_OFF;
            r_q.smp  <= '0;
            r_q.idx  <= '0;
            r_q.dout <= 1'b0;
            r_q.oe   <= 1'b0;
            r_q.cs_q <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state   = r_q.st;
    assign dout    = r_q.dout;
    assign dout_oe = r_q.oe;

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int WIDTH     = 12,
    parameter int SMP_EDGES = 2,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             dclk,
    input  logic             zero_tail,
    input  logic [WIDTH-1:0] result,
    output logic             dout,
    output logic             dout_oe,
    output logic             sampling,
    output logic             converting,
    output logic             analog_off,
    output logic             full_off
);

    logic            fall;
    logic            pick_bit;
    logic [IDXW-1:0] pick_idx;
    seq_state_e      state;

    sar_fall_detect u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (dclk),
        .fall  (fall)
    );

    sar_bit_pick #(.WIDTH(WIDTH)) u_pick (
        .word  (result),
        .idx   (pick_idx),
        .bit_o (pick_bit)
    );

    sar_seq_fsm #(.WIDTH(WIDTH), .SMP_EDGES(SMP_EDGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .fall      (fall),
        .zero_tail (zero_tail),
        .pick_bit  (pick_bit),
        .pick_idx  (pick_idx),
        .state     (state),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assign sampling   = (state == ST_SAMPLE);
    assign converting = (state == ST_NULL) || (state == ST_MSB);
    assign full_off   = (state == ST_OFF);
    assign analog_off = (state == ST_OFF) || (state == ST_LSB) ||
                        (state == ST_ZERO) || (state == ST_DONE);

endmodule

// File: rtl/sar_serial_seq_checker.sv
module sar_serial_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dclk,
    input logic dout,
    input logic dout_oe,
    input logic sampling,
    input logic converting,
    input logic analog_off,
    input logic full_off
);

    logic dclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dclk_prev <= 1'b0;
        else        dclk_prev <= dclk;
    end

    // R1: no drive during the sampling window
    p_quiet_sampling_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> !dout_oe);

    // R2: entering conversion drives the low null bit
    p_null_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converting) |-> (dout_oe && !dout));

    // R3: data only moves on a falling data clock while selected
    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !(dclk_prev && !dclk)) |=> $stable(dout));

    // R7: select high releases the line and powers down fully
    p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && full_off));

    // R8: status flags mutually exclusive
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sampling, converting, analog_off}));

    // R8: full power-down implies analog power-down
    p_full_implies_analog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_off |-> analog_off);

endmodule

bind sar_serial_seq sar_serial_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .dclk       (dclk),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .sampling   (sampling),
    .converting (converting),
    .analog_off (analog_off),
    .full_off   (full_off)
);

// File: tb/test_sar_serial_seq.sv
module test_sar_serial_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  oe;
        logic  d;
        logic  smp;
        logic  conv;
        logic  aoff;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        dclk = 1'b0;
    logic        zero_tail = 1'b0;
    logic [11:0] result = 12'h000;
    logic        dout, dout_oe, sampling, converting, analog_off, full_off;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    exp_t sb_q[$];
    event mon_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_serial_seq i_sar_serial_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .dclk       (dclk),
        .zero_tail  (zero_tail),
        .result     (result),
        .dout       (dout),
        .dout_oe    (dout_oe),
        .sampling   (sampling),
        .converting (converting),
        .analog_off (analog_off),
        .full_off   (full_off)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: pops expectations and compares with outputs
    always @(mon_ev) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {3'b0, dout_oe, dout, sampling, converting, analog_off},
                     {3'b0, e.oe, e.d, e.smp, e.conv, e.aoff});
    end

    // Expected outputs after falling edge k of a frame
    function automatic exp_t model(int k, logic [11:0] w, bit zt, string tag);
        exp_t e;
        e.tag = tag; e.oe = 0; e.d = 0; e.smp = 0; e.conv = 0; e.aoff = 0;
        if (k == 1) begin
            e.smp = 1;
        end else if (k == 2) begin
            e.oe = 1; e.conv = 1;
        end else if (k <= 14) begin
            e.oe = 1; e.conv = 1; e.d = w[14 - k];
        end else begin
            e.aoff = 1;
            if (zt) begin
                e.oe = 1;
            end else if (k <= 25) begin
                e.oe = 1; e.d = w[k - 14];
            end
        end
        return e;
    endfunction

    task automatic fall_edge(input int k, input string tag);
        sb_q.push_back(model(k, result, zero_tail, tag));
        @(negedge clk) dclk = 1'b1;
        repeat (4) @(negedge clk);
        dclk = 1'b0;
        repeat (4) @(negedge clk);
        -> mon_ev;
        #1;
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk) cs_n = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [11:0] w, input int first, input int last, input string tag);
        result = w;
        for (int k = first; k <= last; k++) fall_edge(k, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 reset", {5'b0, dout_oe, full_off, analog_off}, {5'b0, 1'b0, 1'b1, 1'b1});

        // R1: select falls, sampling without drive
        set_cs(1'b0);
        check("R1 sampling", {6'b0, sampling, dout_oe}, {6'b0, 1'b1, 1'b0});

        // R3 R5: alternating word, LSB replay, release and idle edges
        zero_tail = 1'b0;
        frame(12'hA5C, 1, 26, "R3_R5 frame A5C");
        result = 12'hFFF;
        fall_edge(27, "R5 idle after release");
        fall_edge(28, "R5 idle after release");

        // R7: select high powers down
        set_cs(1'b1);
        check("R7 full_off", {6'b0, dout_oe, full_off}, {6'b0, 1'b0, 1'b1});

        // R10: extreme codes
        set_cs(1'b0);
        frame(12'h000, 1, 16, "R10 code 000");
        set_cs(1'b1);
        set_cs(1'b0);
        frame(12'hFFF, 1, 26, "R10 code FFF");
        set_cs(1'b1);

        // R6: zero tail
        zero_tail = 1'b1;
        set_cs(1'b0);
        frame(12'h3C3, 1, 20, "R6 zero tail");
        set_cs(1'b1);
        zero_tail = 1'b0;

        // R7: abort mid-frame, then restart
        set_cs(1'b0);
        frame(12'h6A9, 1, 6, "R7 before abort");
        set_cs(1'b1);
        check("R7 abort", {5'b0, dout_oe, full_off, analog_off}, {5'b0, 1'b0, 1'b1, 1'b1});
        set_cs(1'b0);
        check("R7 restart sampling", {7'b0, sampling}, 8'd1);
        frame(12'h155, 1, 26, "R7 restarted frame");
        set_cs(1'b1);

        // R4: result changes between edges, no pipeline delay
        set_cs(1'b0);
        frame(12'h800, 1, 3, "R4 before change");
        frame(12'h7FF, 4, 14, "R4 after change");
        frame(12'h0A0, 15, 26, "R4 replay word");
        set_cs(1'b1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule